// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Comparator

This block sits in the digital half of an integer-N synthesizer loop. It divides an incoming reference clock by a programmable ratio R+1 to form the comparison strobe `fc`. It then compares the rising edges of that strobe with the rising edges of the divided oscillator feedback `fp`, and reports which of the two came first on two active-low correction outputs. Each correction output stays low for as many sampling cycles as the two edges are apart. A lock flag is raised once the loop has held its phase error under a programmable bound for a run of comparison periods.

All logic runs on one fast sampling clock. Both `ref_in` and `fp_in` pass through a two-flop synchronizer, and only their 0-to-1 transitions count. A ratio value of zero makes every reference rising edge produce a comparison strobe, so the reference reaches the comparator undivided. The charge pump and loop filter that consume `up_n`/`down_n` are outside this block.

Top module: `refpfd_top`

## Requirements
- R1: While `rst` is high, on the following clock edge `up_n` and `down_n` read 1, `lock` and `fc` read 0, and the divide counter is cleared. After reset, the first `fc` pulse comes on the (R+1)-th reference rising edge.
- R2: `fc` is a one-cycle high pulse on every (R+1)-th rising edge of `ref_in`. When `ref_in` is first seen high at clock edge k, the pulse is visible after edge k+2.
- R3: With R = 0, every rising edge of `ref_in` produces an `fc` pulse.
- R4: If R is lowered below the number of reference edges already counted, the next reference rising edge produces `fc` and restarts the count from zero.
- R5: When an `fc` pulse comes N cycles (N > 0) before the `fp` rising edge is registered, `up_n` is low for exactly N cycles and `down_n` stays high. The `fp` edge is registered with the same latency as `fc`.
- R6: When the `fp` edge comes N cycles before `fc`, `down_n` is low for exactly N cycles and `up_n` stays high.
- R7: When `fc` and the registered `fp` edge fall in the same cycle, neither output goes low.
- R8: Only rising edges act. Holding `ref_in` high for many cycles gives a single `fc` pulse.
- R9: `up_n` and `down_n` are never low in the same cycle.
- R10: A comparison period ends when both edges have been seen. Its width is the number of cycles its correction output was low. `lock` rises one cycle after the 16th consecutive period whose width is below `lock_thr`.
- R11: `lock` drops, and the run count restarts, one cycle after a period's width reaches `lock_thr`. This happens even while the pulse is still in progress.
- R12: Repeated `fc` pulses with no `fp` edge keep `up_n` low until an `fp` edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fp_in | input | 1 | Divided feedback, asynchronous to clk |
| r_div | input | RW (6) | Reference ratio R, divide by R+1 |
| lock_thr | input | TW (8) | Width bound, in cycles, for a good period |
| fc | output | 1 | Comparison strobe, one-cycle pulse |
| up_n | output | 1 | Active-low, reference leads feedback |
| down_n | output | 1 | Active-low, feedback leads reference |
| lock | output | 1 | Lock flag |

## Verification
The `fc` pulse and the registered feedback edge are both due after the third clock edge that follows an input rise. The correction outputs change one edge after that, and `lock` changes one edge after the period ends or overflows. The bench applies inputs half a cycle before an edge and samples outputs at the falling edge. Each cycle it compares the outputs with a cycle-stepped model whose pipeline depths are taken from these latencies. Directed cases add pulse-width and strobe counts taken over whole stimulus windows, so a wrong latency or width shows up both in the counts and in the per-cycle comparison.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;
  typedef struct packed {
    logic fc;
    logic fp;
  } cmp_ev_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ref_div.sv
module ref_div #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_rise,
  input  logic [RW-1:0] ratio,
  output logic          fc_q
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fc_q <= 1'b0;
    end else begin
      fc_q <= 1'b0;
      if (ref_rise) begin
        if (cnt >= ratio) begin
          cnt  <= '0;
          fc_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: strobe lasts a single cycle
  a_r2_fc_single: assert property (@(posedge clk) disable iff (rst)
    fc_q |=> !fc_q);
  // R3: ratio zero passes each edge
  a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && ratio == '0) |=> fc_q);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import refpfd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cmp_ev_t ev,
  output logic    up_n,
  output logic    down_n,
  output logic    active,
  output logic    close
);
  logic up_q, dn_q;
  logic u_seen, d_seen;

  assign u_seen = up_q | ev.fc;
  assign d_seen = dn_q | ev.fp;
  assign close  = u_seen & d_seen;
  assign active = up_q | dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= u_seen & ~d_seen;
      dn_q <= d_seen & ~u_seen;
    end
  end

  assign up_n   = ~up_q;
  assign down_n = ~dn_q;

  // R1: reset releases both outputs
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (up_n && down_n));
  // R9: outputs never active together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!up_n && !down_n));
  // R5: up pulse starts only from a strobe
  a_r5_up_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(up_n) |-> $past(ev.fc));
  // R6: down pulse starts only from a feedback edge
  a_r6_dn_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(down_n) |-> $past(ev.fp));
  // R7: coincident edges from idle give no pulse
  a_r7_coincide: assert property (@(posedge clk) disable iff (rst)
    (up_n && down_n && ev.fc && ev.fp) |=> (up_n && down_n));
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int TW     = 8,
  parameter int LOCK_N = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          close,
  input  logic [TW-1:0] thr,
  output logic          lock
);
  localparam int GW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam logic [TW-1:0] WMAX = '1;
  localparam logic [GW-1:0] GLAST = GW'(LOCK_N - 1);

  logic [TW-1:0] wcnt;
  logic [GW-1:0] gcnt;
  logic [TW:0]   meas;
  logic          over;

  assign meas = {1'b0, wcnt} + {{TW{1'b0}}, active};
  assign over = meas >= {1'b0, thr};

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      gcnt <= '0;
      lock <= 1'b0;
    end else begin
      if (close)                       wcnt <= '0;
      else if (active && wcnt != WMAX) wcnt <= wcnt + 1'b1;

      if ((active || close) && over) begin
        gcnt <= '0;
        lock <= 1'b0;
      end else if (close) begin
        if (gcnt == GLAST) lock <= 1'b1;
        else               gcnt <= gcnt + 1'b1;
      end
    end
  end

  // R10: lock only rises at the end of a period
  a_r10_rise_on_close: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(close));
  // R11: lock only falls while a comparison is in progress or ending
  a_r11_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> $past(active || close));
endmodule

// File: rtl/refpfd_top.sv
module refpfd_top
  import refpfd_pkg::*;
#(
  parameter int RW     = 6,
  parameter int TW     = 8,
  parameter int LOCK_N = 16,
  parameter int SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          fp_in,
  input  logic [RW-1:0] r_div,
  input  logic [TW-1:0] lock_thr,
  output logic          fc,
  output logic          up_n,
  output logic          down_n,
  output logic          lock
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in, rise;
  logic           fc_q, fp_q;
  logic           active, close;
  cmp_ev_t        ev;

  assign raw_in = {fp_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise[g])
    );
  end

  ref_div #(.RW(RW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .ratio    (r_div),
    .fc_q     (fc_q)
  );

  // feedback edge registered to match the divider's output stage
  always_ff @(posedge clk) begin
    if (rst) fp_q <= 1'b0;
    else     fp_q <= rise[1];
  end

  assign ev.fc = fc_q;
  assign ev.fp = fp_q;
  assign fc    = fc_q;

  pfd_core u_pfd (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .up_n   (up_n),
    .down_n (down_n),
    .active (active),
    .close  (close)
  );

  lock_det #(.TW(TW), .LOCK_N(LOCK_N)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .close  (close),
    .thr    (lock_thr),
    .lock   (lock)
  );

  // R1: reset clears strobe and lock
  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> (!fc && !lock));
endmodule

// File: tb/sim_refpfd_top.sv
module sim_refpfd_top;
  localparam int CLK_P = 10;
  localparam int RW = 6;
  localparam int TW = 8;
  localparam int WLIM = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fp_in = 1'b0;
  logic [RW-1:0] r_div = '0;
  logic [TW-1:0] lock_thr = 8'd4;
  logic fc, up_n, down_n, lock;

  int total = 0, bad = 0;
  int fc_cnt = 0, up_low = 0, dn_low = 0, both_low = 0;
  bit model_on = 1'b0;

  // model state
  int  mcnt, mw, mg;
  bit  mfc, mfp, mup, mdn, mlock;
  bit  [2:0] rs, fs;

  refpfd_top u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fp_in(fp_in),
    .r_div(r_div), .lock_thr(lock_thr),
    .fc(fc), .up_n(up_n), .down_n(down_n), .lock(lock)
  );

  always #(CLK_P/2) clk = ~clk;

  // cycle model built from the stated latencies
  always @(posedge clk) begin
    bit u, d, cl, act, over, redge, fedge;
    int meas;
    if (rst) begin
      mcnt = 0; mw = 0; mg = 0;
      mfc = 0; mfp = 0; mup = 0; mdn = 0; mlock = 0;
      rs = '0; fs = '0;
    end else begin
      u = mup | mfc; d = mdn | mfp; cl = u & d; act = mup | mdn;
      meas = mw + int'(act);
      over = meas >= int'(lock_thr);
      if ((act || cl) && over) begin mg = 0; mlock = 0; end
      else if (cl) begin
        if (mg == 15) mlock = 1; else mg = mg + 1;
      end
      if (cl) mw = 0; else if (act && mw != WLIM) mw = mw + 1;
      mup = u & ~d; mdn = d & ~u;
      redge = rs[1] & ~rs[2];
      fedge = fs[1] & ~fs[2];
      mfc = 0;
      if (redge) begin
        if (mcnt >= int'(r_div)) begin mfc = 1; mcnt = 0; end
        else mcnt = mcnt + 1;
      end
      mfp = fedge;
      rs = {rs[1:0], ref_in};
      fs = {fs[1:0], fp_in};
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (fc) fc_cnt++;
    if (!up_n) up_low++;
    if (!down_n) dn_low++;
    if (!up_n && !down_n) both_low++;
    if (model_on && !rst) begin
      chk("R2 fc", int'(fc), int'(mfc));
      chk("R5 up_n", int'(up_n), int'(!mup));
      chk("R6 down_n", int'(down_n), int'(!mdn));
      chk("R10 lock", int'(lock), int'(mlock));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; ref_in = 1'b0; fp_in = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  // ofs > 0: feedback rises ofs cycles after reference
  task automatic pair(input int ofs);
    int b_r, b_f, len;
    b_r = (ofs < 0) ? -ofs : 0;
    b_f = (ofs < 0) ? 0 : ofs;
    len = b_r + b_f + 12;
    for (int t = 0; t < len; t++) begin
      ref_in = (t >= b_r && t < b_r + 3);
      fp_in  = (t >= b_f && t < b_f + 3);
      step(1);
    end
  endtask

  task automatic ref_pulse(input int hi);
    ref_in = 1'b1; step(hi);
    ref_in = 1'b0; step(3);
  endtask

  task automatic fp_pulse();
    fp_in = 1'b1; step(3);
    fp_in = 1'b0; step(4);
  endtask

  initial begin
    int s_up, s_dn, s_fc;
    void'($urandom(32'h5eed1234));
    step(2);
    // R1: outputs held during reset
    chk("R1 up_n", int'(up_n), 1);
    chk("R1 down_n", int'(down_n), 1);
    chk("R1 lock", int'(lock), 0);
    chk("R1 fc", int'(fc), 0);
    rst = 1'b0;
    model_on = 1'b1;
    step(2);

    // R5 / R6 / R7: pulse widths with R = 0
    r_div = '0; lock_thr = 8'd200;
    for (int k = -5; k <= 5; k++) begin
      s_up = up_low; s_dn = dn_low;
      pair(k);
      chk("R5 up width", up_low - s_up, (k > 0) ? k : 0);
      chk("R6 down width", dn_low - s_dn, (k < 0) ? -k : 0);
    end
    s_up = up_low; s_dn = dn_low;
    pair(0);
    chk("R7 coincide", (up_low - s_up) + (dn_low - s_dn), 0);

    // R3: every reference edge passes with R = 0
    do_reset();
    r_div = '0; s_fc = fc_cnt;
    for (int i = 0; i < 5; i++) ref_pulse(3);
    chk("R3 pass count", fc_cnt - s_fc, 5);
    // R12: up_n held low across repeated strobes
    chk("R12 up held", int'(up_n), 0);
    fp_pulse();
    chk("R12 up released", int'(up_n), 1);

    // R2 / R1: divide by 4, first strobe on 4th edge
    do_reset();
    r_div = 6'd3; s_fc = fc_cnt;
    for (int i = 0; i < 3; i++) ref_pulse(3);
    chk("R1 first strobe not early", fc_cnt - s_fc, 0);
    ref_pulse(3);
    chk("R2 first strobe", fc_cnt - s_fc, 1);
    for (int i = 0; i < 4; i++) ref_pulse(3);
    chk("R2 divide count", fc_cnt - s_fc, 2);

    // R2 latency: strobe after edge k+2
    do_reset();
    r_div = '0;
    ref_in = 1'b1; step(1);   // sampled at edge k
    chk("R2 not at k", int'(fc), 0);
    step(1);
    chk("R2 not at k+1", int'(fc), 0);
    step(1);
    chk("R2 at k+2", int'(fc), 1);
    step(1);
    chk("R2 one cycle", int'(fc), 0);

    // R8: long high level gives one strobe
    s_fc = fc_cnt;
    step(20);
    ref_in = 1'b0; step(4);
    chk("R8 level ignored", fc_cnt - s_fc, 0);
    fp_pulse();

    // R4: lowering R mid-count
    do_reset();
    r_div = 6'd10; s_fc = fc_cnt;
    for (int i = 0; i < 3; i++) ref_pulse(3);
    chk("R4 before change", fc_cnt - s_fc, 0);
    r_div = 6'd1;
    ref_pulse(3);
    chk("R4 immediate strobe", fc_cnt - s_fc, 1);
    ref_pulse(3);
    chk("R4 restart count", fc_cnt - s_fc, 1);
    ref_pulse(3);
    chk("R4 after restart", fc_cnt - s_fc, 2);

    // R10 / R11: lock run
    do_reset();
    r_div = '0; lock_thr = 8'd4;
    for (int i = 0; i < 15; i++) pair(2);
    chk("R10 not yet", int'(lock), 0);
    pair(-3);
    chk("R10 lock set", int'(lock), 1);
    pair(6);
    chk("R11 lock drop", int'(lock), 0);
    for (int i = 0; i < 15; i++) pair(0);
    chk("R10 restart run", int'(lock), 0);
    pair(1);
    chk("R10 relock", int'(lock), 1);

    // random pairs and random levels, checked by the model
    for (int n = 0; n < 300; n++) begin
      r_div = RW'($urandom_range(0, 2));
      lock_thr = TW'($urandom_range(0, 12));
      pair($urandom_range(0, 12) - 6);
    end
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) ref_in = ~ref_in;
      if ($urandom_range(0, 3) == 0) fp_in = ~fp_in;
      if ($urandom_range(0, 199) == 0) r_div = RW'($urandom_range(0, 5));
      step(1);
    end
    // R9: never both low
    chk("R9 exclusive", both_low, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule